// File: doc/BRIEF.md
# PWM Timer with Half-Step Duty Resolution

This block is a 16-bit up-counting pulse-width timer with two outputs, A and B. One compare value (the period value) sets the length of a PWM period and a second compare value (the duty value) sets the point at which the outputs turn active. The block runs from one system clock at twice the count-clock rate. It splits that clock into alternating rising and falling count-clock phases, and the main counter advances once per phase pair.

In half-step mode a second, dual-edge counter advances on every system clock. The duty compare uses that counter in place of the main counter, which doubles the duty resolution. The period compare always stays on the main counter. Half-step mode is refused when either output uses mode 2 or 3. A configuration error is flagged when the period value is too large for the duty value. New compare values take effect only at the period wrap, or at once while the timer is stopped.

Top module: `pwm_halfstep_timer`

## Requirements
- R1: While running, `count_o` holds for two system clocks (phase 0 then phase 1) and then steps by one. When it equals the latched period value at the end of phase 1 it wraps to 0, so one period lasts period+1 count clocks.
- R2: `match_b_o` is high exactly in the phase-0 cycle in which `count_o` equals the latched period value, in both normal and half-step mode.
- R3: In normal resolution, with mode 1 and no inversion, an output is high when `count_o` >= latched duty value and low otherwise.
- R4: In half-step mode, the duty compare uses the dual-edge value 2·count + phase (0 … 2·period+1). With mode 1 and no inversion, an output is high when that value >= latched duty value.
- R5: `match_a_o` is high exactly in the phase-0 cycle in which `count_o` equals the latched duty value, and never while half-step mode is in effect.
- R6: Half-step mode is in effect only when `half_i` is 1 and neither mode field is 2 or 3. Otherwise both outputs use normal resolution and `cfg_err_o` is 0.
- R7: Mode codes per output: 0 = off, 1 = PWM, 2 and 3 = PWM that also blocks half-step mode. An inversion input of 1 inverts the output in every mode and while stopped.
- R8: In mode 0 an output sits at its inactive level (equal to its inversion input).
- R9: `cfg_err_o` is 1 exactly when half-step mode is in effect and `ccb_i` >= `cca_i`/2 (rounded down) + 0x8000.
- R10: With `run_i` low at a clock edge, the counter, the phase and the dual-edge counter clear to 0. While `run_i` is low, both outputs sit at their inactive level and both match pulses are low.
- R11: `cca_i` and `ccb_i` are latched only at the period wrap, or on any edge while stopped. A change in mid-period has no effect on the outputs until the wrap.
- R12: After synchronous reset with `run_i` low, `count_o` is 0, the match pulses are 0 and each output equals its inversion input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the count-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Run enable; low stops and clears the timer |
| half_i | input | 1 | Request half-step duty resolution |
| mode_a_i | input | 2 | Output A mode code |
| mode_b_i | input | 2 | Output B mode code |
| inv_a_i | input | 1 | Invert output A |
| inv_b_i | input | 1 | Invert output B |
| cca_i | input | 16 | Duty compare value |
| ccb_i | input | 16 | Period compare value |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |
| count_o | output | 16 | Main counter value |
| match_a_o | output | 1 | Duty compare match pulse |
| match_b_o | output | 1 | Period compare match pulse |
| cfg_err_o | output | 1 | Half-step configuration error |

## Verification
The counter, phase and latched compare values are registers, so they change one clock edge after the inputs that cause them. The outputs, the match pulses and the error flag are combinational from those registers and the current mode, inversion and half-step inputs, so they are valid in the same cycle. The bench changes inputs at the falling edge and advances its own reference model by exactly one edge per clock. It compares every output at the next falling edge, and this covers both delays with no extra allowance. The configuration error depends only on the present inputs and is checked in the same cycle as it is driven.

// File: rtl/pwm_pkg.sv
// Shared definitions for the half-step PWM timer.
// Assumes the 2-bit output-mode field coding listed below.
package pwm_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_PWM  = 2'd1,
        MODE_PWMX = 2'd2,
        MODE_PWMY = 2'd3
    } out_mode_e;

    // True when a mode code forbids half-step operation.
    function automatic logic blocks_half(input logic [1:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/pwm_timebase.sv
// Time base: makes the count-clock phase, the main counter, the dual-edge
// counter and the compare values latched at wrap. Assumes clk runs at twice
// the count-clock rate. The main counter steps at the end of phase 1.
module pwm_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cca_in,
    input  logic [W-1:0] ccb_in,
    output logic         phase,
    output logic [W-1:0] count,
    output logic [W:0]   dual,
    output logic [W-1:0] cca_q,
    output logic [W-1:0] ccb_q,
    output logic         match_b
);
    logic main_wrap;
    logic dual_end;

    // End of period seen by the main counter and, separately, by the dual counter.
    assign main_wrap = phase && (count == ccb_q);
    assign dual_end  = (dual == {ccb_q, 1'b1});

    // Phase, counters and compare latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            count <= '0;
            dual  <= '0;
            cca_q <= '0;
            ccb_q <= '0;
        end else if (!run) begin
            phase <= 1'b0;
            count <= '0;
            dual  <= '0;
            cca_q <= cca_in;
            ccb_q <= ccb_in;
        end else begin
            phase <= ~phase;
            dual  <= dual_end ? '0 : dual + 1'b1;
            if (main_wrap) begin
                count <= '0;
                cca_q <= cca_in;
                ccb_q <= ccb_in;
            end else if (phase) begin
                count <= count + 1'b1;
            end
        end
    end

    // Period match pulse in the first phase of the last count.
    assign match_b = run && !phase && (count == ccb_q);

    // R1
    count_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ccb_q);
    // R4
    dual_follows_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dual == {count, phase});
    // R1
    count_holds_phase0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !phase) |=> $stable(count));
    // R11
    latch_only_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !main_wrap) |=> ($stable(cca_q) && $stable(ccb_q)));
    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0 && !phase));
endmodule

// File: rtl/pwm_cfg_guard.sv
// Decides whether half-step mode is in effect and flags a period value that
// is too large for it. Pure combinational; works on the live inputs.
module pwm_cfg_guard
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         half_req,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    input  logic [W-1:0] cca_in,
    input  logic [W-1:0] ccb_in,
    output logic         half_on,
    output logic         cfg_err
);
    localparam logic [W:0] HALF_SPAN = (W+1)'(1) << (W-1);

    logic [W:0] limit;

    // Half-step is refused when either output uses a blocking mode.
    assign half_on = half_req && !blocks_half(mode_a) && !blocks_half(mode_b);

    // Limit = duty/2 + half the counter range.
    assign limit   = {2'b00, cca_in[W-1:1]} + HALF_SPAN;
    assign cfg_err = half_on && ({1'b0, ccb_in} >= limit);
endmodule

// File: rtl/pwm_out_stage.sv
// One PWM output: compares the latched duty value against the main counter
// or the dual-edge counter, then applies the mode and the inversion.
// Assumes the counters are already cleared while stopped.
module pwm_out_stage
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         half_on,
    input  logic [1:0]   mode,
    input  logic         inv,
    input  logic [W-1:0] count,
    input  logic [W:0]   dual,
    input  logic [W-1:0] cca_q,
    output logic         pin
);
    logic active;

    // Duty compare at the selected resolution.
    assign active = half_on ? (dual >= {1'b0, cca_q}) : (count >= cca_q);

    // Mode gating and inversion.
    assign pin = (run && (out_mode_e'(mode) != MODE_OFF)) ? (active ^ inv) : inv;

    // R8
    off_is_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (pin == inv));
    // R10
    stopped_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pin == inv));
endmodule

// File: rtl/pwm_halfstep_timer.sv
// Top level: PWM timer with two outputs, period set by ccb_i, duty by cca_i,
// optional half-step duty resolution. One system clock at twice the count rate.
module pwm_halfstep_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         half_i,
    input  logic [1:0]   mode_a_i,
    input  logic [1:0]   mode_b_i,
    input  logic         inv_a_i,
    input  logic         inv_b_i,
    input  logic [W-1:0] cca_i,
    input  logic [W-1:0] ccb_i,
    output logic         pwm_a_o,
    output logic         pwm_b_o,
    output logic [W-1:0] count_o,
    output logic         match_a_o,
    output logic         match_b_o,
    output logic         cfg_err_o
);
    localparam int NCH = 2;

    logic         phase;
    logic [W-1:0] count;
    logic [W:0]   dual;
    logic [W-1:0] cca_q;
    logic [W-1:0] ccb_q;
    logic         half_on;
    logic [1:0]   mode_v [NCH];
    logic         inv_v  [NCH];
    logic         pin_v  [NCH];

    pwm_timebase #(.W(W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run_i),
        .cca_in(cca_i), .ccb_in(ccb_i),
        .phase(phase), .count(count), .dual(dual),
        .cca_q(cca_q), .ccb_q(ccb_q), .match_b(match_b_o)
    );

    pwm_cfg_guard #(.W(W)) u_guard (
        .half_req(half_i), .mode_a(mode_a_i), .mode_b(mode_b_i),
        .cca_in(cca_i), .ccb_in(ccb_i),
        .half_on(half_on), .cfg_err(cfg_err_o)
    );

    // Per-channel controls gathered for the generate loop.
    assign mode_v[0] = mode_a_i;
    assign mode_v[1] = mode_b_i;
    assign inv_v[0]  = inv_a_i;
    assign inv_v[1]  = inv_b_i;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_out_stage #(.W(W)) u_out (
            .clk(clk), .rst_n(rst_n), .run(run_i), .half_on(half_on),
            .mode(mode_v[i]), .inv(inv_v[i]),
            .count(count), .dual(dual), .cca_q(cca_q),
            .pin(pin_v[i])
        );
    end

    assign pwm_a_o = pin_v[0];
    assign pwm_b_o = pin_v[1];
    assign count_o = count;

    // Duty match pulse, suppressed in half-step mode.
    assign match_a_o = run_i && !half_on && !phase && (count == cca_q);

    // R5
    no_match_a_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_on |-> !match_a_o);
    // R6
    no_err_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a_i[1] || mode_b_i[1]) |-> !cfg_err_o);
    // R2
    match_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_b_o |=> !match_b_o);
endmodule

// File: tb/tb_pwm_halfstep_timer.sv
module tb_pwm_halfstep_timer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b0, half_i = 1'b0, inv_a_i = 1'b0, inv_b_i = 1'b0;
    logic [1:0] mode_a_i = 2'd1, mode_b_i = 2'd1;
    logic [W-1:0] cca_i = '0, ccb_i = '0;
    logic pwm_a_o, pwm_b_o, match_a_o, match_b_o, cfg_err_o;
    logic [W-1:0] count_o;

    int checks = 0, errors = 0, cyc = 0;
    int m_tc = 0, m_ph = 0, m_a = 0, m_b = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_halfstep_timer #(.W(W)) dut (.*);

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int half_eff();
        return (half_i && !mode_a_i[1] && !mode_b_i[1]) ? 1 : 0;
    endfunction

    function automatic int exp_err();
        return (half_eff() != 0 && int'(ccb_i) >= int'(cca_i) / 2 + 32768) ? 1 : 0;
    endfunction

    function automatic int exp_pin(int mode, int inv);
        int act;
        if (!run_i || mode == 0) return inv;
        act = (half_eff() != 0) ? ((2*m_tc + m_ph >= m_a) ? 1 : 0)
                                : ((m_tc >= m_a) ? 1 : 0);
        return act ^ inv;
    endfunction

    // Reference model step for the coming rising edge.
    task automatic advance();
        if (!rst_n) begin
            m_tc = 0; m_ph = 0; m_a = 0; m_b = 0;
        end else if (!run_i) begin
            m_tc = 0; m_ph = 0; m_a = int'(cca_i); m_b = int'(ccb_i);
        end else begin
            if (m_ph == 1) begin
                if (m_tc == m_b) begin
                    m_tc = 0; m_a = int'(cca_i); m_b = int'(ccb_i);
                end else m_tc++;
            end
            m_ph = 1 - m_ph;
        end
    endtask

    task automatic compare_all();
        int mb, ma;
        mb = (run_i && m_ph == 0 && m_tc == m_b) ? 1 : 0;
        ma = (run_i && half_eff() == 0 && m_ph == 0 && m_tc == m_a) ? 1 : 0;
        check("R1 count", int'(count_o), m_tc);
        check("R2 match_b", int'(match_b_o), mb);
        check("R5 match_a", int'(match_a_o), ma);
        check("R3/R4/R7/R8 pwm_a", int'(pwm_a_o), exp_pin(int'(mode_a_i), int'(inv_a_i)));
        check("R3/R4/R7/R8 pwm_b", int'(pwm_b_o), exp_pin(int'(mode_b_i), int'(inv_b_i)));
        check("R6/R9 cfg_err", int'(cfg_err_o), exp_err());
    endtask

    task automatic tick();
        advance();
        @(negedge clk);
        cyc++;
        compare_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) tick();
        // R12: reset state with inversion on output B
        inv_b_i = 1'b1;
        tick();
        check("R12 reset pwm_b", int'(pwm_b_o), 1);
        check("R12 reset count", int'(count_o), 0);
        rst_n = 1'b1;

        // Directed: period 5, duty 1, normal then half-step (R3, R4)
        cca_i = 16'd1; ccb_i = 16'd5; inv_b_i = 1'b0;
        tick();
        run_i = 1'b1;
        repeat (30) tick();
        half_i = 1'b1;
        repeat (30) tick();
        // R6: mode 3 on B blocks half-step, match_a returns
        mode_b_i = 2'd3;
        repeat (30) tick();
        mode_b_i = 2'd1;
        // R11: mid-period duty change waits for wrap
        half_i = 1'b0;
        repeat (3) tick();
        cca_i = 16'd4;
        repeat (14) tick();
        // R10: stop clears the counter and parks the outputs
        run_i = 1'b0; inv_a_i = 1'b1;
        tick();
        check("R10 stopped count", int'(count_o), 0);
        check("R10 stopped pwm_a", int'(pwm_a_o), 1);
        inv_a_i = 1'b0;

        // R9: boundary of the period limit in half-step mode
        half_i = 1'b1; cca_i = 16'h2000; ccb_i = 16'h9000;
        tick();
        check("R9 at limit", int'(cfg_err_o), 1);
        ccb_i = 16'h8FFF;
        tick();
        check("R9 below limit", int'(cfg_err_o), 0);
        cca_i = 16'h2001; ccb_i = 16'h9000;
        tick();
        check("R9 odd duty at limit", int'(cfg_err_o), 1);
        mode_a_i = 2'd2;
        tick();
        check("R6 blocked no err", int'(cfg_err_o), 0);
        mode_a_i = 2'd1;

        // Random phase
        cca_i = 16'd2; ccb_i = 16'd6; run_i = 1'b1;
        for (int i = 0; i < 8000; i++) begin
            if ($urandom_range(7) == 0) begin
                cca_i = 16'($urandom_range(15));
                ccb_i = 16'($urandom_range(12));
            end
            if ($urandom_range(63) == 0) begin
                half_i   = 1'($urandom_range(1));
                mode_a_i = 2'($urandom_range(3));
                mode_b_i = 2'($urandom_range(3));
                inv_a_i  = 1'($urandom_range(1));
                inv_b_i  = 1'($urandom_range(1));
            end
            if ($urandom_range(199) == 0) run_i = ~run_i;
            if (!run_i && $urandom_range(7) == 0) run_i = 1'b1;
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule